// File: doc/BRIEF.md
# External Asynchronous Bus Access Sequencer

This block runs read and write cycles on an off-chip asynchronous memory bus for a single internal requester. The bus serves six spaces: four memory banks (indices 0 to 3), an I/O space (index 4) and a boot space (index 5). The requester supplies the space index with each request, so no address decoding happens here. Each space has its own configuration word. The word sets separate read and write wait counts, how the strobe phase is allowed to end, a clock divide ratio for bus timing, an optional extra hold period after writes, the strobe polarity, and whether the data bus is 8 or 16 bits wide.

A request is a level on `req` that carries the space, direction, word address, write data and byte enables. The block latches all of these together with the selected space's configuration. It then steps through a setup phase, a strobe phase and a hold phase, all counted in divided clocks. It closes with a one-cycle acknowledge that also returns the read data. A 16-bit access to a space set to 8 bits runs one byte cycle for each enabled byte, low byte first.

Top module: `xbus_sequencer`

## Requirements
- R1: While and after reset, `req_ack` is low, both strobes are high (the reset configuration is active-low), and every `bus_sel_n` line is high.
- R2: Each space has its own 15-bit configuration word, written through `cfg_we`/`cfg_idx`/`cfg_wdata` with this layout: bit 14 wide (1 = 16-bit bus), bit 13 strobe active-high, bit 12 write hold extension, bits 11:10 divide code, bits 9:8 completion mode, bits 7:4 write wait, bits 3:0 read wait. The word is captured when a request is accepted, so a write that lands during an active cycle takes effect from the next request onward.
- R3: Each byte or word beat lasts one divided clock of setup, then the strobe phase, then one divided clock of hold. The acknowledge is a single-cycle pulse after the last beat. When the request is accepted at clock edge 1, the acknowledge is visible after edge 1 + beats × ratio × (2 + strobe_ticks + hold_extra).
- R4: Reads use the read wait count and writes use the write wait count. Without acknowledge effects, the strobe lasts wait + 1 divided clocks.
- R5: The completion mode decides when the strobe phase ends, checked on each divided clock edge. Mode 0 ends on the count alone. Mode 1 needs both the count and a high `bus_ack`. Mode 2 ends on whichever comes first. Mode 3 behaves like mode 0.
- R6: With hold extension set, a write beat's hold phase is two divided clocks instead of one. Reads ignore the setting.
- R7: Strobe polarity follows the active space's configuration. Between cycles, the strobes rest at the inactive level of the last space used.
- R8: On a 16-bit space, one beat drives `bus_addr = {addr,0}`, `bus_dout = wdata` and `bus_be_n = ~enables`, and returns all of `bus_din`. On an 8-bit space, each enabled byte gets its own beat, low byte first. That beat drives `bus_addr = {addr,lane}`, puts the byte on `bus_dout[7:0]` with the upper lines at 0, and sets `bus_be_n = 2'b10`. It places `bus_din[7:0]` into the matching lane of the read data; lanes that are not enabled read 0. Byte enables of 00 count as both bytes.
- R9: Divide codes 0, 1, 2 and 3 give ratios of 1, 2, 4 and 8 core clocks per divided clock, and every phase length scales by that ratio.
- R10: Only one request is in flight at a time. While a cycle is active, changes to the request inputs have no effect on the bus or on the result.
- R11: The read and write strobes are never active together. At most one select is active, and it is the selected space's select, held from setup through hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request level, held until acknowledge |
| req_space | input | 3 | Space index 0..5 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables (bit 0 = low byte) |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data, valid with `req_ack` |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Space whose configuration is written |
| cfg_wdata | input | 15 | Configuration word |
| bus_addr | output | 17 | Byte address on the bus |
| bus_dout | output | 16 | Write data on the bus |
| bus_din | input | 16 | Read data from the bus |
| bus_be_n | output | 2 | Active-low byte lane enables |
| bus_rd | output | 1 | Read strobe, polarity per space |
| bus_wr | output | 1 | Write strobe, polarity per space |
| bus_sel_n | output | 6 | Active-low select, one per space |
| bus_ack | input | 1 | External acknowledge, synchronous to `clk` |

## Verification
The hardest situations to reach are a strobe whose length depends on when the external acknowledge arrives relative to the divided-clock edges, and a configuration write that lands in the middle of a cycle. The bench plays the device: it raises `bus_ack` once the strobe has been active for a programmed number of core clocks, so modes 1 and 2 end either before or after the wait count depending on the ratio. A sweep covers every space, divide code, mode, direction and width. Separate directed runs rewrite the active space's configuration mid-cycle and scramble the request inputs during a cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int WAIT_W = 4;
  localparam int DIV_W  = 2;
  localparam int TCNT_W = (1 << DIV_W) - 1;
  localparam int DW     = 16;
  localparam int BW     = DW / 2;

  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_DONE} phase_e;

  typedef struct packed {
    logic              wide;
    logic              act_high;
    logic              hold_ext;
    logic [DIV_W-1:0]  div_code;
    logic [1:0]        mode;
    logic [WAIT_W-1:0] wr_wait;
    logic [WAIT_W-1:0] rd_wait;
  } space_cfg_t;

  localparam int CFG_W = $bits(space_cfg_t);

  // core clocks per divided clock
  function automatic int unsigned div_ratio(input logic [DIV_W-1:0] code);
    return 32'd1 << code;
  endfunction

  // strobe completion rule per mode
  function automatic logic strobe_may_end(input logic [1:0] mode, input logic count_ok,
                                          input logic ext_ok);
    case (mode)
      2'd1:    return count_ok && ext_ok;
      2'd2:    return count_ok || ext_ok;
      default: return count_ok;
    endcase
  endfunction

  // zero enables mean the whole word
  function automatic logic [1:0] lanes_of(input logic [1:0] be);
    return (be == 2'b00) ? 2'b11 : be;
  endfunction
endpackage

// File: rtl/xbus_cfg_bank.sv
module xbus_cfg_bank
  import xbus_pkg::*;
#(
  parameter int NSPACE = 6,
  parameter int SIDX_W = 3,
  parameter logic [CFG_W-1:0] RST_CFG = 15'h40FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SIDX_W-1:0] wr_idx,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic [SIDX_W-1:0] rd_idx,
  output space_cfg_t        rd_cfg
);
  space_cfg_t regs [NSPACE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSPACE; i++) regs[i] <= space_cfg_t'(RST_CFG);
    end else if (wr_en) begin
      for (int i = 0; i < NSPACE; i++)
        if (wr_idx == SIDX_W'(i)) regs[i] <= space_cfg_t'(wr_data);
    end
  end

  always_comb begin
    rd_cfg = space_cfg_t'(RST_CFG);
    for (int i = 0; i < NSPACE; i++)
      if (rd_idx == SIDX_W'(i)) rd_cfg = regs[i];
  end
endmodule

// File: rtl/xbus_tick.sv
module xbus_tick
  import xbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_code,
  output logic             tick
);
  logic [TCNT_W-1:0] cnt;
  logic [TCNT_W-1:0] last;

  assign last = TCNT_W'(div_ratio(div_code) - 32'd1);
  assign tick = run && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // R9
  tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= last);
endmodule

// File: rtl/xbus_lane.sv
module xbus_lane
  import xbus_pkg::*;
(
  input  logic          wide,
  input  logic          lane,
  input  logic [1:0]    lanes,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] rdata_q,
  output logic [DW-1:0] dout,
  output logic [1:0]    be_n,
  output logic [DW-1:0] rdata_next
);
  always_comb begin
    if (wide) begin
      dout       = wdata;
      be_n       = ~lanes;
      rdata_next = din;
    end else begin
      dout       = {{BW{1'b0}}, lane ? wdata[DW-1:BW] : wdata[BW-1:0]};
      be_n       = 2'b10;
      rdata_next = rdata_q;
      if (lane) rdata_next[DW-1:BW] = din[BW-1:0];
      else      rdata_next[BW-1:0]  = din[BW-1:0];
    end
  end
endmodule

// File: rtl/xbus_sequencer.sv
module xbus_sequencer
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NSPACE = 6,
  parameter logic [CFG_W-1:0] RST_CFG = 15'h40FF,
  localparam int SIDX_W = $clog2(NSPACE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [SIDX_W-1:0] req_space,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [1:0]        req_be,
  output logic              req_ack,
  output logic [DW-1:0]     req_rdata,
  input  logic              cfg_we,
  input  logic [SIDX_W-1:0] cfg_idx,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [ADDR_W:0]   bus_addr,
  output logic [DW-1:0]     bus_dout,
  input  logic [DW-1:0]     bus_din,
  output logic [1:0]        bus_be_n,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [NSPACE-1:0] bus_sel_n,
  input  logic              bus_ack
);
  phase_e            ph;
  space_cfg_t        cfg_pick, cur;
  logic [SIDX_W-1:0] cur_sp;
  logic [ADDR_W-1:0] cur_addr;
  logic [DW-1:0]     cur_wd, rdata_q, rdata_next;
  logic [1:0]        cur_lanes, req_lanes;
  logic              cur_wr, lane, more, hold_x;
  logic [WAIT_W-1:0] wcnt, wait_sel;

  // named internal events
  logic run, tick, accept, count_ok, strobe_end, rd_on, wr_on;

  xbus_cfg_bank #(.NSPACE(NSPACE), .SIDX_W(SIDX_W), .RST_CFG(RST_CFG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_data(cfg_wdata),
    .rd_idx(req_space), .rd_cfg(cfg_pick));

  xbus_tick u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .div_code(cur.div_code), .tick(tick));

  xbus_lane u_lane (
    .wide(cur.wide), .lane(lane), .lanes(cur_lanes), .wdata(cur_wd), .din(bus_din),
    .rdata_q(rdata_q), .dout(bus_dout), .be_n(bus_be_n), .rdata_next(rdata_next));

  assign req_lanes  = lanes_of(req_be);
  assign run        = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
  assign accept     = (ph == PH_IDLE) && req;
  assign wait_sel   = cur_wr ? cur.wr_wait : cur.rd_wait;
  assign count_ok   = (wcnt >= wait_sel);
  assign strobe_end = (ph == PH_STROBE) && tick && strobe_may_end(cur.mode, count_ok, bus_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      cur       <= space_cfg_t'(RST_CFG);
      cur_sp    <= '0;
      cur_addr  <= '0;
      cur_wd    <= '0;
      cur_lanes <= 2'b11;
      cur_wr    <= 1'b0;
      lane      <= 1'b0;
      more      <= 1'b0;
      hold_x    <= 1'b0;
      wcnt      <= '0;
      rdata_q   <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (accept) begin
          ph        <= PH_SETUP;
          cur       <= cfg_pick;
          cur_sp    <= req_space;
          cur_addr  <= req_addr;
          cur_wd    <= req_wdata;
          cur_wr    <= req_write;
          cur_lanes <= req_lanes;
          lane      <= !cfg_pick.wide && !req_lanes[0];
          more      <= !cfg_pick.wide && (req_lanes == 2'b11);
          rdata_q   <= '0;
        end
        PH_SETUP: if (tick) begin
          ph   <= PH_STROBE;
          wcnt <= '0;
        end
        PH_STROBE: begin
          if (strobe_end) begin
            ph     <= PH_HOLD;
            hold_x <= cur_wr && cur.hold_ext;
            if (!cur_wr) rdata_q <= rdata_next;
          end else if (tick && (wcnt != '1)) begin
            wcnt <= wcnt + 1'b1;
          end
        end
        PH_HOLD: if (tick) begin
          if (hold_x) hold_x <= 1'b0;
          else if (more) begin
            ph   <= PH_SETUP;
            lane <= 1'b1;
            more <= 1'b0;
          end else ph <= PH_DONE;
        end
        PH_DONE: ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign rd_on     = (ph == PH_STROBE) && !cur_wr;
  assign wr_on     = (ph == PH_STROBE) && cur_wr;
  assign bus_rd    = cur.act_high ? rd_on : !rd_on;
  assign bus_wr    = cur.act_high ? wr_on : !wr_on;
  assign bus_addr  = {cur_addr, cur.wide ? 1'b0 : lane};
  assign req_ack   = (ph == PH_DONE);
  assign req_rdata = rdata_q;

  for (genvar g = 0; g < NSPACE; g++) begin : g_sel
    assign bus_sel_n[g] = !(run && (cur_sp == SIDX_W'(g)));
  end

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(rd_on && wr_on));
  // R11
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~bus_sel_n));
  // R3
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ack |=> !req_ack);
  // R5
  mode1_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_end && cur.mode == 2'd1) |-> bus_ack);
  // R9
  strobe_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ph) == PH_STROBE && ph != PH_STROBE) |-> $past(tick));
  // R2
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_IDLE && $past(ph) != PH_IDLE) |-> $stable(cur));
endmodule

// File: tb/sim_xbus_sequencer.sv
module sim_xbus_sequencer;
  import xbus_pkg::*;
  localparam int AW = 16;
  localparam int NS = 6;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req = 1'b0, req_write = 1'b0;
  logic [SW-1:0] req_space = '0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_be = '0;
  logic          req_ack;
  logic [15:0]   req_rdata;
  logic          cfg_we = 1'b0;
  logic [SW-1:0] cfg_idx = '0;
  logic [14:0]   cfg_wdata = '0;
  logic [AW:0]   bus_addr;
  logic [15:0]   bus_dout, bus_din;
  logic [1:0]    bus_be_n;
  logic          bus_rd, bus_wr;
  logic [NS-1:0] bus_sel_n;
  logic          bus_ack = 1'b0;

  int n_chk = 0, n_bad = 0;
  logic [14:0] shadow [NS];

  assign bus_din = {~bus_addr[7:0], bus_addr[7:0] ^ 8'h3C};

  xbus_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_space(req_space), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_ack(req_ack),
    .req_rdata(req_rdata), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din), .bus_be_n(bus_be_n),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_sel_n(bus_sel_n), .bus_ack(bus_ack));

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [14:0] mk(input bit wide, input bit pol, input bit hx,
                                     input int dc, input int md, input int wrw, input int rdw);
    return {wide, pol, hx, 2'(dc), 2'(md), 4'(wrw), 4'(rdw)};
  endfunction

  task automatic cfg_write(input int sp, input logic [14:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = SW'(sp); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    shadow[sp] = v;
  endtask

  // disturb: 0 none, 1 scramble request inputs mid-cycle, 2 rewrite config mid-cycle
  task automatic do_xfer(input int sp, input bit wr, input logic [AW-1:0] a,
                         input logic [15:0] wd, input logic [1:0] be, input int aw,
                         input int disturb, input logic [14:0] alt);
    logic [14:0] c;
    bit wide, pol, hx, got, act, prev, other, wrong;
    int dc, md, wrw, rdw, dv, w, jf, ca, j, h, p, nb, fl, n, tot, beats, run_cnt, exp_lat;
    logic [1:0] ln;
    logic [15:0] exp_rd;
    logic [AW:0] xa;
    logic [34:0] rec [2];
    logic [34:0] expb [2];
    c = shadow[sp];
    wide = c[14]; pol = c[13]; hx = c[12];
    dc = int'(c[11:10]); md = int'(c[9:8]); wrw = int'(c[7:4]); rdw = int'(c[3:0]);
    dv = 1 << dc;
    w  = wr ? wrw : rdw;
    jf = w + 1;
    ca = (aw + dv - 1) / dv;
    if (ca < 1) ca = 1;
    j = (md == 1) ? ((jf > ca) ? jf : ca) : (md == 2) ? ((jf < ca) ? jf : ca) : jf;
    h = (wr && hx) ? 1 : 0;
    p = dv * (2 + j + h);
    ln = (be == 2'b00) ? 2'b11 : be;
    nb = (!wide && ln == 2'b11) ? 2 : 1;
    fl = (!wide && !ln[0]) ? 1 : 0;
    exp_lat = 1 + nb * p;
    if (wide) begin
      xa = {a, 1'b0};
      exp_rd = {~xa[7:0], xa[7:0] ^ 8'h3C};
      expb[0] = {xa, ~ln, wr ? wd : 16'h0};
      expb[1] = '0;
    end else begin
      exp_rd = '0;
      xa = {a, 1'b0};
      if (ln[0]) exp_rd[7:0] = xa[7:0] ^ 8'h3C;
      xa = {a, 1'b1};
      if (ln[1]) exp_rd[15:8] = xa[7:0] ^ 8'h3C;
      expb[0] = {a, fl[0], 2'b10, wr ? {8'h00, fl ? wd[15:8] : wd[7:0]} : 16'h0};
      expb[1] = {a, 1'b1, 2'b10, wr ? {8'h00, wd[15:8]} : 16'h0};
    end
    rec[0] = '0; rec[1] = '0;
    @(negedge clk);
    req = 1'b1; req_space = SW'(sp); req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    got = 0; prev = 0; wrong = 0; n = 0; tot = 0; beats = 0; run_cnt = 0;
    bus_ack = (aw == 0);
    while (!got && n < 3000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (disturb == 1 && n == 3) begin
        req_addr = ~a; req_space = SW'((sp + 1) % NS); req_wdata = ~wd; req_write = ~wr;
      end
      if (disturb == 2 && n == 3) begin
        cfg_we = 1'b1; cfg_idx = SW'(sp); cfg_wdata = alt;
      end
      if (disturb == 2 && n == 4) cfg_we = 1'b0;
      act   = wr ? (pol ? bus_wr : !bus_wr) : (pol ? bus_rd : !bus_rd);
      other = wr ? (pol ? bus_rd : !bus_rd) : (pol ? bus_wr : !bus_wr);
      if (other) wrong = 1;
      if (act) begin
        tot++; run_cnt++;
        if (beats < 2) rec[beats] = {bus_addr, bus_be_n, wr ? bus_dout : 16'h0};
        if (bus_sel_n != ~(NS'(1) << sp)) wrong = 1;
      end else if (prev) begin
        beats++; run_cnt = 0;
      end
      prev = act;
      bus_ack = (run_cnt >= aw);
      if (req_ack) got = 1;
    end
    req = 1'b0;
    if (disturb == 2) shadow[sp] = alt;
    chk(got && n == exp_lat, "R3 R4 R5 R6 R9 latency to acknowledge", n, exp_lat);
    chk(tot == nb * j * dv, "R4 R5 R9 strobe width", tot, nb * j * dv);
    chk(beats == nb, "R8 beat count", beats, nb);
    chk(rec[0] == expb[0], "R8 R10 first beat addr/lanes/data", rec[0], expb[0]);
    if (nb == 2) chk(rec[1] == expb[1], "R8 second beat addr/lanes/data", rec[1], expb[1]);
    chk(!wrong, "R11 strobe and select exclusivity", wrong, 0);
    if (!wr) chk(req_rdata == exp_rd, "R8 read data", req_rdata, exp_rd);
    chk(bus_rd == !pol && bus_wr == !pol && bus_sel_n == '1, "R7 idle levels",
        {bus_rd, bus_wr}, {!pol, !pol});
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL R3 watchdog expired: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) shadow[i] = 15'h40FF;
    repeat (3) @(negedge clk);
    // R1 state during reset
    chk(!req_ack && bus_rd && bus_wr && bus_sel_n == '1, "R1 reset outputs",
        {req_ack, bus_rd, bus_wr, bus_sel_n}, {1'b0, 1'b1, 1'b1, 6'h3F});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!req_ack && bus_rd && bus_wr && bus_sel_n == '1, "R1 after reset",
        {req_ack, bus_rd, bus_wr, bus_sel_n}, {1'b0, 1'b1, 1'b1, 6'h3F});

    // sweep: every space, divide code, mode, direction, width
    for (int sp = 0; sp < NS; sp++)
      for (int dc = 0; dc < 4; dc++)
        for (int md = 0; md < 4; md++)
          for (int wr = 0; wr < 2; wr++)
            for (int wd = 0; wd < 2; wd++) begin
              logic [AW-1:0] a;
              a = AW'(16'h1230 + sp * 16'h111 + dc * 7 + md * 3 + wr);
              cfg_write(sp, mk(wd[0], ((md + sp) % 2) == 1, ((dc + sp) % 2) == 1, dc, md,
                               (sp + md) % 3 + 1, (sp + dc) % 3));
              do_xfer(sp, wr[0], a, 16'hA000 ^ (a * 3), 2'((sp + md + dc) % 4),
                      (sp * 3 + md + dc) % 7, 0, '0);
            end

    // R2: independent per-space words, mid-cycle write applies to next request only
    cfg_write(0, mk(1, 0, 0, 0, 0, 3, 1));
    cfg_write(1, mk(0, 1, 1, 2, 2, 2, 6));
    do_xfer(0, 1'b0, 16'h0042, 16'h0, 2'b11, 0, 0, '0);
    do_xfer(1, 1'b1, 16'h0043, 16'h5A3C, 2'b11, 9, 0, '0);
    cfg_write(2, mk(1, 0, 0, 1, 0, 2, 2));
    do_xfer(2, 1'b1, 16'h0777, 16'hBEEF, 2'b11, 0, 2, mk(0, 1, 1, 2, 1, 5, 1));
    do_xfer(2, 1'b1, 16'h0778, 16'hCAFE, 2'b11, 3, 0, '0);
    do_xfer(2, 1'b0, 16'h0779, 16'h0, 2'b10, 3, 0, '0);

    // R10: request inputs scrambled while a cycle is active
    cfg_write(3, mk(0, 0, 1, 1, 0, 3, 2));
    do_xfer(3, 1'b1, 16'h2468, 16'h1357, 2'b11, 0, 1, '0);
    do_xfer(3, 1'b0, 16'h2469, 16'h0, 2'b00, 0, 1, '0);

    // R6: hold extension does not lengthen reads
    cfg_write(4, mk(1, 1, 1, 3, 0, 1, 1));
    do_xfer(4, 1'b0, 16'h0101, 16'h0, 2'b11, 0, 0, '0);
    do_xfer(4, 1'b1, 16'h0102, 16'h7E7E, 2'b01, 0, 0, '0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule